// File: doc/BRIEF.md
# Byte-Stream UART Register Front-End

This block is the software-facing register layer of a serial port. It works at byte level: a small memory-mapped register bus lets software set two mode bytes, issue commands, watch status, write bytes to send and read bytes that have arrived. Outgoing bytes leave through a valid/ready byte stream towards a serializer. Incoming bytes enter through a second valid/ready stream into a four-entry receive queue. A single-cycle break pulse from the line side records a break and places a zero byte in the queue. One level-sensitive interrupt line is the masked OR of the interrupt status bits. Bit timing, baud generation and line error detection live elsewhere, and the two baud bytes are plain storage.

Bus accesses last one cycle. `bus_sel` with `bus_wr` high commits a write at the clock edge. `bus_sel` with `bus_wr` low is a read: `bus_rdata` shows the addressed register during that cycle, and a read of the data offset removes the byte it shows at the edge.

Back-pressure rules: on the transmit stream, once `tx_valid` is high, `tx_data` holds steady until the cycle in which `tx_ready` is high. A transmitter reset is the only thing that withdraws a byte early. On the receive stream, `rx_ready` is high only while the receiver is enabled, the queue holds fewer than four bytes and no break pulse is present. A byte moves when `rx_valid` and `rx_ready` are both high at a clock edge.

Top module: `uart_regfront`

## Requirements
- R1: After reset, the mode byte reads 0x00, status reads 0x08 (transmit-empty only), interrupt status and mask are 0, `irq` is low, `rx_ready` and `tx_valid` are low, and both baud bytes read 0.
- R2: Offset 0x00 reaches the first or second mode byte through a pointer. The pointer starts at the first byte. Each write stores into the byte currently selected and then selects the second. A command with miscellaneous field 1 selects the first again.
- R3: Command byte (offset 0x08): bits [6:4] are the miscellaneous action, bits [3:2] are the transmitter field and bits [1:0] are the receiver field. In both the transmitter and receiver fields, 1 enables, 2 disables, and 0 or 3 leaves the enable unchanged. The fields take effect in the order miscellaneous, transmitter, receiver, so a reset combined with an enable in one byte leaves that direction enabled.
- R4: A write to offset 0x0C loads a transmit byte and clears status bit3 (transmit-empty). With the transmitter enabled, the byte appears on `tx_data` with `tx_valid` high. Bit3 is set again once the sink accepts the byte. Status bit2 (transmit-ready) equals the transmitter enable.
- R5: Each write to offset 0x0C yields exactly one transfer. While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` does not change.
- R6: A byte written while the transmitter is disabled is held and not offered. It is offered once an enable command arrives.
- R7: Received bytes are accepted only while `rx_ready` is high (receiver enabled, fewer than 4 bytes queued, no break pulse). Status bit0 (receive-ready) means the queue is non-empty. Status bit1 (full) means it holds 4 bytes.
- R8: A read of offset 0x0C returns the oldest queued byte and removes it, in arrival order. It returns 0x00 when the queue is empty.
- R9: A break pulse sets interrupt status bit2 and queues a 0x00 byte, replacing the newest entry when 4 bytes are queued. It is queued even when the receiver is disabled. Miscellaneous command 5 clears bit2.
- R10: Miscellaneous command 2 disables the receiver and empties the queue, which clears status bits 0 and 1.
- R11: Miscellaneous command 3 disables the transmitter, discards any pending transmit byte (dropping `tx_valid`), and sets transmit-empty.
- R12: Interrupt status (read at offset 0x14) has bit0 equal to transmit-ready. Bit1 follows status bit1 when mode byte one bit6 is set, and status bit0 otherwise. Bit2 is the break flag and bit7 reads 0. A write to 0x14 loads the mask. `irq` is high exactly when status AND mask is nonzero.
- R13: Offsets 0x18 and 0x1C are read/write baud storage bytes. Reads of 0x08, 0x10 and unmapped offsets return 0. Writes to the status offset 0x04 and to unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| tx_valid | output | 1 | Transmit byte offered |
| tx_data | output | 8 | Transmit byte |
| tx_ready | input | 1 | Sink takes the offered byte |
| rx_valid | input | 1 | Received byte offered |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Block accepts the offered byte |
| brk_evt | input | 1 | One-cycle break detected on the line |
| irq | output | 1 | Interrupt request, level |

## Verification
On every cycle, the assertions check the stream rules: a held transmit byte stays stable under back-pressure, and `rx_ready` is never high with a full queue. They also check that the queue never exceeds its depth, that an empty-queue read returns zero, that a break always raises the break flag, that a transmitter reset drops the offered byte, and that a zero mask keeps `irq` low. Only the bench scenarios can show the rest: which enable state results from each command byte, queue ordering, break overwrite of the newest entry, the mode-pointer sequence, and the exact interrupt status value under each receive-interrupt selection.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;
  localparam int DW = 8;

  // register byte offsets
  localparam int OFS_MODE  = 'h00;
  localparam int OFS_STAT  = 'h04;
  localparam int OFS_CMD   = 'h08;
  localparam int OFS_DATA  = 'h0C;
  localparam int OFS_AUX   = 'h10;
  localparam int OFS_INT   = 'h14;
  localparam int OFS_BAUDH = 'h18;
  localparam int OFS_BAUDL = 'h1C;

  // status bit positions
  localparam int ST_RXRDY = 0;
  localparam int ST_FULL  = 1;
  localparam int ST_TXRDY = 2;
  localparam int ST_TXEMP = 3;

  // interrupt status bit positions
  localparam int IS_TX  = 0;
  localparam int IS_RX  = 1;
  localparam int IS_BRK = 2;

  // mode byte one: receive interrupt source select
  localparam int MODE_RXSEL = 6;

  typedef enum logic [2:0] {
    MISC_NOP     = 3'd0,
    MISC_PTR_RST = 3'd1,
    MISC_RX_RST  = 3'd2,
    MISC_TX_RST  = 3'd3,
    MISC_ERR_RST = 3'd4,
    MISC_BRK_CLR = 3'd5,
    MISC_BRK_ON  = 3'd6,
    MISC_BRK_OFF = 3'd7
  } misc_e;

  typedef enum logic [1:0] {
    DIR_KEEP = 2'd0,
    DIR_ON   = 2'd1,
    DIR_OFF  = 2'd2,
    DIR_RSVD = 2'd3
  } dir_e;

  typedef struct packed {
    logic ptr_rst;
    logic rx_rst;
    logic tx_rst;
    logic brk_clr;
    logic tx_on;
    logic tx_off;
    logic rx_on;
    logic rx_off;
  } cmd_t;
endpackage

// File: rtl/uart_cmd_decode.sv
module uart_cmd_decode
  import uart_rf_pkg::*;
(
  input  logic [6:0] cmd_byte,
  output cmd_t       cmd
);
  misc_e misc;
  dir_e  txf;
  dir_e  rxf;

  always_comb begin
    misc = misc_e'(cmd_byte[6:4]);
    txf  = dir_e'(cmd_byte[3:2]);
    rxf  = dir_e'(cmd_byte[1:0]);
    cmd         = '0;
    cmd.ptr_rst = (misc == MISC_PTR_RST);
    cmd.rx_rst  = (misc == MISC_RX_RST);
    cmd.tx_rst  = (misc == MISC_TX_RST);
    cmd.brk_clr = (misc == MISC_BRK_CLR);
    cmd.tx_on   = (txf == DIR_ON);
    cmd.tx_off  = (txf == DIR_OFF);
    cmd.rx_on   = (rxf == DIR_ON);
    cmd.rx_off  = (rxf == DIR_OFF);
  end
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
  import uart_rf_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic                         push,
  input  logic [DW-1:0]                push_data,
  input  logic                         brk,
  input  logic                         pop,
  output logic [DW-1:0]                head,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         full,
  output logic                         empty
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] rd_ptr;
  logic [CW-1:0] cnt;

  logic          do_pop;
  logic          ins;
  logic [DW-1:0] ins_data;
  logic [CW-1:0] cnt_ap;
  logic          full_ap;
  logic [PW-1:0] rd_nxt;
  logic [PW-1:0] woff;

  always_comb begin
    do_pop   = pop && (cnt != '0);
    cnt_ap   = cnt - CW'(do_pop);
    full_ap  = (cnt_ap == CW'(DEPTH));
    rd_nxt   = rd_ptr + PW'(do_pop);
    ins      = push || brk;
    ins_data = brk ? '0 : push_data;
    woff     = full_ap ? PW'(DEPTH-1) : cnt_ap[PW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      cnt    <= '0;
    end else if (flush) begin
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      rd_ptr <= rd_nxt;
      if (ins && !full_ap) cnt <= cnt_ap + CW'(1);
      else                 cnt <= cnt_ap;
    end
  end

  always_ff @(posedge clk) begin
    if (!flush && ins) mem[rd_nxt + woff] <= ins_data;
  end

  assign count = cnt;
  assign empty = (cnt == '0);
  assign full  = (cnt == CW'(DEPTH));
  assign head  = empty ? '0 : mem[rd_ptr];
endmodule

// File: rtl/uart_tx_path.sv
module uart_tx_path
  import uart_rf_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  input  logic          tx_en,
  input  logic          tx_rst,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  input  logic          out_ready,
  output logic          empty
);
  logic          hold_v;
  logic [DW-1:0] hold_d;
  logic          out_v;
  logic [DW-1:0] out_d;
  logic          fire;
  logic          launch;

  always_comb begin
    fire   = out_v && out_ready;
    launch = hold_v && tx_en && (!out_v || fire);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_v <= 1'b0;
      hold_d <= '0;
      out_v  <= 1'b0;
      out_d  <= '0;
    end else if (tx_rst) begin
      hold_v <= 1'b0;
      out_v  <= 1'b0;
    end else begin
      if (fire) out_v <= 1'b0;
      if (launch) begin
        out_v  <= 1'b1;
        out_d  <= hold_d;
        hold_v <= 1'b0;
      end
      if (load) begin
        hold_v <= 1'b1;
        hold_d <= load_data;
      end
    end
  end

  assign out_valid = out_v;
  assign out_data  = out_d;
  assign empty     = !hold_v && !out_v;
endmodule

// File: rtl/uart_regfront.sv
module uart_regfront
  import uart_rf_pkg::*;
#(
  parameter int FIFO_DEPTH = 4,
  parameter int ADDR_W     = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              tx_valid,
  output logic [DW-1:0]     tx_data,
  input  logic              tx_ready,
  input  logic              rx_valid,
  input  logic [DW-1:0]     rx_data,
  output logic              rx_ready,
  input  logic              brk_evt,
  output logic              irq
);
  localparam int CW = $clog2(FIFO_DEPTH+1);

  logic          wr_en, rd_en;
  logic          mode_wr, cmd_wr, data_wr, int_wr, bh_wr, bl_wr, data_rd;
  cmd_t          cmd;

  logic [DW-1:0] mode0_q, mode1_q;
  logic          mode_ptr_q;
  logic          tx_en_q, rx_en_q;
  logic          dbrk_q;
  logic [DW-1:0] imr_q;
  logic [DW-1:0] baud_hi_q, baud_lo_q;

  logic [DW-1:0] fifo_head;
  logic [CW-1:0] fifo_cnt;
  logic          fifo_full, fifo_empty;
  logic          tx_empty;
  logic          rx_push;
  logic          rx_int;
  logic [DW-1:0] status_w;
  logic [DW-1:0] isr_w;

  always_comb begin
    wr_en   = bus_sel && bus_wr;
    rd_en   = bus_sel && !bus_wr;
    mode_wr = wr_en && (bus_addr == ADDR_W'(OFS_MODE));
    cmd_wr  = wr_en && (bus_addr == ADDR_W'(OFS_CMD));
    data_wr = wr_en && (bus_addr == ADDR_W'(OFS_DATA));
    int_wr  = wr_en && (bus_addr == ADDR_W'(OFS_INT));
    bh_wr   = wr_en && (bus_addr == ADDR_W'(OFS_BAUDH));
    bl_wr   = wr_en && (bus_addr == ADDR_W'(OFS_BAUDL));
    data_rd = rd_en && (bus_addr == ADDR_W'(OFS_DATA));
  end

  uart_cmd_decode u_dec (
    .cmd_byte (bus_wdata[6:0]),
    .cmd      (cmd)
  );

  // mode bytes and pointer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode0_q    <= '0;
      mode1_q    <= '0;
      mode_ptr_q <= 1'b0;
    end else begin
      if (mode_wr) begin
        if (mode_ptr_q) mode1_q <= bus_wdata;
        else            mode0_q <= bus_wdata;
        mode_ptr_q <= 1'b1;
      end else if (cmd_wr && cmd.ptr_rst) begin
        mode_ptr_q <= 1'b0;
      end
    end
  end

  // direction enables: misc field first, then direction fields
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_en_q <= 1'b0;
      rx_en_q <= 1'b0;
    end else if (cmd_wr) begin
      if (cmd.tx_on)                    tx_en_q <= 1'b1;
      else if (cmd.tx_off || cmd.tx_rst) tx_en_q <= 1'b0;
      if (cmd.rx_on)                    rx_en_q <= 1'b1;
      else if (cmd.rx_off || cmd.rx_rst) rx_en_q <= 1'b0;
    end
  end

  // break flag, mask and baud storage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dbrk_q    <= 1'b0;
      imr_q     <= '0;
      baud_hi_q <= '0;
      baud_lo_q <= '0;
    end else begin
      if (brk_evt)                      dbrk_q <= 1'b1;
      else if (cmd_wr && cmd.brk_clr)   dbrk_q <= 1'b0;
      if (int_wr) imr_q     <= bus_wdata;
      if (bh_wr)  baud_hi_q <= bus_wdata;
      if (bl_wr)  baud_lo_q <= bus_wdata;
    end
  end

  assign rx_ready = rx_en_q && !fifo_full && !brk_evt;
  assign rx_push  = rx_valid && rx_ready;

  uart_rx_fifo #(.DEPTH(FIFO_DEPTH)) u_rxq (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (cmd_wr && cmd.rx_rst),
    .push      (rx_push),
    .push_data (rx_data),
    .brk       (brk_evt),
    .pop       (data_rd),
    .head      (fifo_head),
    .count     (fifo_cnt),
    .full      (fifo_full),
    .empty     (fifo_empty)
  );

  uart_tx_path u_txp (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (data_wr),
    .load_data (bus_wdata),
    .tx_en     (tx_en_q),
    .tx_rst    (cmd_wr && cmd.tx_rst),
    .out_valid (tx_valid),
    .out_data  (tx_data),
    .out_ready (tx_ready),
    .empty     (tx_empty)
  );

  always_comb begin
    status_w           = '0;
    status_w[ST_RXRDY] = !fifo_empty;
    status_w[ST_FULL]  = fifo_full;
    status_w[ST_TXRDY] = tx_en_q;
    status_w[ST_TXEMP] = tx_empty;

    rx_int         = mode0_q[MODE_RXSEL] ? fifo_full : !fifo_empty;
    isr_w          = '0;
    isr_w[IS_TX]   = tx_en_q;
    isr_w[IS_RX]   = rx_int;
    isr_w[IS_BRK]  = dbrk_q;
  end

  assign irq = |(isr_w & imr_q);

  always_comb begin
    bus_rdata = '0;
    if (rd_en) begin
      case (int'(bus_addr))
        OFS_MODE:  bus_rdata = mode_ptr_q ? mode1_q : mode0_q;
        OFS_STAT:  bus_rdata = status_w;
        OFS_DATA:  bus_rdata = fifo_head;
        OFS_INT:   bus_rdata = isr_w;
        OFS_BAUDH: bus_rdata = baud_hi_q;
        OFS_BAUDL: bus_rdata = baud_lo_q;
        default:   bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/uart_regfront_chk.sv
module uart_regfront_chk
  import uart_rf_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 6
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       bus_sel,
  input logic                       bus_wr,
  input logic [ADDR_W-1:0]          bus_addr,
  input logic [DW-1:0]              bus_wdata,
  input logic [DW-1:0]              bus_rdata,
  input logic                       tx_valid,
  input logic [DW-1:0]              tx_data,
  input logic                       tx_ready,
  input logic                       rx_ready,
  input logic                       brk_evt,
  input logic                       irq,
  input logic [$clog2(DEPTH+1)-1:0] fifo_cnt,
  input logic [DW-1:0]              imr_q,
  input logic                       tx_empty,
  input logic                       dbrk_q,
  input logic                       tx_en_q
);
  localparam int CW = $clog2(DEPTH+1);

  logic cmd_w, txrst_w, txrst_only_w, pop_w;
  assign cmd_w        = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_CMD));
  assign txrst_w      = cmd_w && (bus_wdata[6:4] == 3'd3);
  assign txrst_only_w = txrst_w && (bus_wdata[3:2] != 2'd1);
  assign pop_w        = bus_sel && !bus_wr && (bus_addr == ADDR_W'(OFS_DATA));

  // R5
  a_r5_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !txrst_w) |=> (tx_valid && $stable(tx_data)));

  // R4
  a_r4_offer_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !tx_empty);

  // R7
  a_r7_no_accept_full: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_cnt == CW'(DEPTH)) |-> !rx_ready);

  // R7
  a_r7_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= CW'(DEPTH));

  // R8
  a_r8_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_w && fifo_cnt == '0) |-> (bus_rdata == '0));

  // R9
  a_r9_brk_flag: assert property (@(posedge clk) disable iff (!rst_n)
    brk_evt |=> dbrk_q);

  // R11
  a_r11_tx_reset: assert property (@(posedge clk) disable iff (!rst_n)
    txrst_only_w |=> (!tx_valid && !tx_en_q && tx_empty));

  // R12
  a_r12_mask_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (imr_q == '0) |-> !irq);
endmodule

bind uart_regfront uart_regfront_chk #(.DEPTH(FIFO_DEPTH), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .tx_valid  (tx_valid),
  .tx_data   (tx_data),
  .tx_ready  (tx_ready),
  .rx_ready  (rx_ready),
  .brk_evt   (brk_evt),
  .irq       (irq),
  .fifo_cnt  (fifo_cnt),
  .imr_q     (imr_q),
  .tx_empty  (tx_empty),
  .dbrk_q    (dbrk_q),
  .tx_en_q   (tx_en_q)
);

// File: tb/tb_uart_regfront.sv
`timescale 1ns/1ps
module tb_uart_regfront;
  localparam int A_MODE = 'h00, A_STAT = 'h04, A_CMD = 'h08, A_DATA = 'h0C;
  localparam int A_AUX = 'h10, A_INT = 'h14, A_BH = 'h18, A_BL = 'h1C;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_sel, bus_wr;
  logic [5:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic       tx_valid, tx_ready;
  logic [7:0] tx_data;
  logic       rx_valid, rx_ready;
  logic [7:0] rx_data;
  logic       brk_evt, irq;

  int nvec = 0;
  int nfail = 0;
  bit done = 1'b0;
  logic [7:0] sink [64];
  int sink_n = 0;

  always #2 clk = ~clk;

  uart_regfront dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .brk_evt(brk_evt), .irq(irq)
  );

  // transmit sink: a handshake seen after a falling edge completes at the next rising edge
  always @(negedge clk) begin
    #1;
    if (rst_n && tx_valid && tx_ready && sink_n < 64) begin
      sink[sink_n] = tx_data;
      sink_n++;
    end
  end

  task automatic ck(input string tag, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 6'(a); bus_wdata = 8'(d);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 6'(a);
    #1 d = int'(bus_rdata);
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic rdck(input string tag, input int a, input int exp);
    int d;
    rd(a, d);
    ck(tag, d, exp);
  endtask

  task automatic push(input int d, output int acc);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = 8'(d);
    #1 acc = int'(rx_ready);
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic brk();
    @(negedge clk);
    brk_evt = 1'b1;
    @(negedge clk);
    brk_evt = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sweep_imr(input string tag, input int isr);
    rdck({tag, " isr"}, A_INT, isr);
    for (int m = 0; m < 256; m++) begin
      wr(A_INT, m);
      #1 ck({tag, " irq"}, int'(irq), int'((isr & m) != 0));
    end
    wr(A_INT, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nvec++; nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    int acc, s, txb, cnt, pre, d;
    rst_n = 1'b0; bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    tx_ready = 0; rx_valid = 0; rx_data = 0; brk_evt = 0;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    rdck("R1 mode", A_MODE, 0);
    rdck("R1 status", A_STAT, 8'h08);
    rdck("R1 isr", A_INT, 0);
    rdck("R1 baud hi", A_BH, 0);
    rdck("R1 baud lo", A_BL, 0);
    #1;
    ck("R1 irq", int'(irq), 0);
    ck("R1 rx_ready", int'(rx_ready), 0);
    ck("R1 tx_valid", int'(tx_valid), 0);

    // R2 mode pointer
    wr(A_MODE, 8'h5A);
    rdck("R2 second byte selected", A_MODE, 0);
    wr(A_MODE, 8'hC3);
    rdck("R2 second byte", A_MODE, 8'hC3);
    wr(A_CMD, 8'h10);
    rdck("R2 ptr reset first byte", A_MODE, 8'h5A);
    wr(A_MODE, 8'h11);
    rdck("R2 after write ptr second", A_MODE, 8'hC3);
    wr(A_CMD, 8'h10);
    rdck("R2 first byte rewritten", A_MODE, 8'h11);
    wr(A_MODE, 8'h00);

    // R3 command sweep: every direction code from every prior enable state
    for (int p = 0; p < 4; p++) begin
      for (int c = 0; c < 16; c++) begin
        int ptx, prx, etx, erx;
        ptx = (p >> 1) & 1; prx = p & 1;
        wr(A_CMD, (ptx ? 4 : 8) | (prx ? 1 : 2));
        wr(A_CMD, c);
        etx = (((c >> 2) & 3) == 1) ? 1 : (((c >> 2) & 3) == 2) ? 0 : ptx;
        erx = ((c & 3) == 1) ? 1 : ((c & 3) == 2) ? 0 : prx;
        #1 ck("R3 rx enable", int'(rx_ready), erx);
        rdck("R3 tx enable in status", A_STAT, 8'h08 | (etx << 2));
      end
    end
    wr(A_CMD, 8'h0A);
    wr(A_CMD, 8'h34);
    rdck("R3 tx reset then enable", A_STAT, 8'h0C);
    wr(A_CMD, 8'h21);
    #1 ck("R3 rx reset then enable", int'(rx_ready), 1);

    // R4 / R5 transmit with back-pressure
    tx_ready = 1'b0;
    wr(A_DATA, 8'hA5);
    rdck("R4 empty cleared", A_STAT, 8'h04);
    #1;
    ck("R4 tx_valid", int'(tx_valid), 1);
    ck("R4 tx_data", int'(tx_data), 8'hA5);
    for (int i = 0; i < 5; i++) begin
      idle(1);
      #1;
      ck("R5 valid held", int'(tx_valid), 1);
      ck("R5 data held", int'(tx_data), 8'hA5);
    end
    ck("R5 nothing sent under back-pressure", sink_n, 0);
    @(negedge clk) tx_ready = 1'b1;
    idle(4);
    ck("R5 one transfer", sink_n, 1);
    ck("R4 byte sent", int'(sink[0]), 8'hA5);
    rdck("R4 empty again", A_STAT, 8'h0C);
    for (int i = 0; i < 16; i++) wr(A_DATA, (i * 17 + 3) & 8'hFF);
    idle(6);
    ck("R5 count after burst", sink_n, 17);
    for (int i = 0; i < 16; i++) ck("R4 burst order", int'(sink[i + 1]), (i * 17 + 3) & 8'hFF);

    // R6 held while disabled
    wr(A_CMD, 8'h08);
    wr(A_DATA, 8'h3C);
    idle(4);
    #1 ck("R6 not offered", int'(tx_valid), 0);
    rdck("R6 status disabled loaded", A_STAT, 8'h00);
    ck("R6 nothing sent", sink_n, 17);
    wr(A_CMD, 8'h04);
    idle(4);
    ck("R6 sent on enable", sink_n, 18);
    ck("R6 byte", int'(sink[17]), 8'h3C);
    rdck("R6 status", A_STAT, 8'h0C);

    // R11 transmitter reset withdraws the byte
    @(negedge clk) tx_ready = 1'b0;
    wr(A_DATA, 8'h77);
    idle(3);
    #1 ck("R11 offered before reset", int'(tx_valid), 1);
    wr(A_CMD, 8'h30);
    #1 ck("R11 tx_valid dropped", int'(tx_valid), 0);
    rdck("R11 status", A_STAT, 8'h08);
    @(negedge clk) tx_ready = 1'b1;
    wr(A_CMD, 8'h04);
    idle(4);
    ck("R11 byte discarded", sink_n, 18);
    txb = 8'h0C;

    // R7 / R8 receive queue sweep over fill levels
    for (int n = 0; n < 6; n++) begin
      for (int k = 0; k < n; k++) begin
        push(8'h40 + n * 8 + k, acc);
        ck("R7 accept", acc, int'(k < 4));
      end
      cnt = (n > 4) ? 4 : n;
      rdck("R7 status", A_STAT, txb | int'(cnt > 0) | (int'(cnt == 4) << 1));
      #1 ck("R7 rx_ready", int'(rx_ready), int'(cnt < 4));
      for (int k = 0; k <= cnt; k++)
        rdck("R8 pop order", A_DATA, (k < cnt) ? (8'h40 + n * 8 + k) : 0);
      rdck("R8 status drained", A_STAT, txb);
    end
    wr(A_CMD, 8'h02);
    push(8'h99, acc);
    ck("R7 disabled refuses", acc, 0);
    rdck("R8 empty read", A_DATA, 0);
    wr(A_CMD, 8'h01);

    // R9 break
    brk();
    rdck("R9 zero queued", A_STAT, txb | 1);
    rdck("R9 isr", A_INT, 8'h07);
    rdck("R9 zero byte", A_DATA, 0);
    rdck("R9 drained", A_STAT, txb);
    wr(A_CMD, 8'h50);
    rdck("R9 flag cleared", A_INT, 8'h01);
    for (int k = 0; k < 4; k++) push(8'hA0 + k, acc);
    brk();
    rdck("R9 still full", A_STAT, txb | 3);
    for (int k = 0; k < 4; k++) rdck("R9 overwrite newest", A_DATA, (k < 3) ? 8'hA0 + k : 0);
    rdck("R9 empty after", A_DATA, 0);
    wr(A_CMD, 8'h02);
    brk();
    wr(A_CMD, 8'h01);
    rdck("R9 break while disabled", A_STAT, txb | 1);
    rdck("R9 zero byte disabled", A_DATA, 0);
    wr(A_CMD, 8'h50);

    // R10 receiver reset
    push(8'h21, acc);
    push(8'h22, acc);
    wr(A_CMD, 8'h20);
    #1 ck("R10 disabled", int'(rx_ready), 0);
    rdck("R10 flushed status", A_STAT, txb);
    rdck("R10 flushed data", A_DATA, 0);
    push(8'h55, acc);
    ck("R10 refuses", acc, 0);
    wr(A_CMD, 8'h01);

    // R12 interrupt status and mask sweep
    sweep_imr("R12 idle", 8'h01);
    push(8'h61, acc); push(8'h62, acc);
    sweep_imr("R12 ready select", 8'h03);
    wr(A_CMD, 8'h10);
    wr(A_MODE, 8'h40);
    sweep_imr("R12 full select partial", 8'h01);
    push(8'h63, acc); push(8'h64, acc);
    brk();
    sweep_imr("R12 full select full brk", 8'h07);
    wr(A_CMD, 8'h20);
    wr(A_CMD, 8'h50);
    wr(A_CMD, 8'h11);
    wr(A_MODE, 8'h00);

    // R13 storage and ignored accesses
    wr(A_BH, 8'h9C);
    wr(A_BL, 8'h27);
    rdck("R13 baud hi", A_BH, 8'h9C);
    rdck("R13 baud lo", A_BL, 8'h27);
    rdck("R13 aux read", A_AUX, 0);
    rdck("R13 cmd read", A_CMD, 0);
    rdck("R13 unmapped read", 'h3C, 0);
    wr(A_STAT, 8'hFF);
    rdck("R13 status write ignored", A_STAT, txb);
    wr('h24, 8'hFF);
    rdck("R13 unmapped write ignored", A_INT, 8'h01);
    #1 ck("R13 mask untouched", int'(irq), 0);
    pre = sink_n; d = 0; s = 0;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule